// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration header of one bus function and serves register accesses of one, two or four bytes in little-endian order. Every write is filtered through a per-byte write-protect map. The map comes in two variants. The plain-function variant is selected when the header type is 0x00 or 0x80. The bridge variant is selected for any other header type. Identification bytes and the type bits of the address windows are loaded from parameters at reset. All other bytes reset to zero.

A four-byte write that lands in the address-window area bypasses the byte filter when the window is implemented. The stored word is aligned to the window size. General windows get their fixed type bits put back, and the expansion-ROM word keeps its enable bit. The block raises a one-cycle remap strobe whenever software may have moved or enabled a decode window. A bridge header also keeps a copy of the secondary bus number.

The access port is single-cycle. A request is sampled on a clock edge, and the acknowledge, read data, remap strobe and bus-number update all appear after that edge.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, bytes 0x00–0x01 hold the vendor ID, 0x02–0x03 the device ID, 0x0A–0x0B the class code, 0x0E the header type, 0x2C–0x2D the subsystem vendor ID and 0x2E–0x2F the subsystem ID (all little-endian). The low byte of each implemented general window holds its type bits, and every other byte is zero. During reset, ack, rdata, remap_pulse and sec_bus are zero.
- R2: ack is high in exactly the cycle after a request is sampled with req_valid high. The read data is valid in that same cycle.
- R3: req_len encodes 0 as 1 byte, 1 as 2 bytes and 2 or 3 as 4 bytes. A 4-byte read is served only when the address is at most 0xFC. A 2-byte read (or a 4-byte read that falls back) is served only when the address is at most 0xFE. Otherwise one byte is returned. Byte addr goes to rdata[7:0], and unused upper bytes read as zero.
- R4: With header type 0x00 or 0x80, byte writes leave 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x2C–0x2F, 0x30–0x33 and 0x3D unchanged.
- R5: With any other header type, byte writes leave 0x00–0x03, 0x08–0x0B, 0x0E, 0x2C–0x2F, 0x38–0x3B and 0x3D unchanged. Window and ROM bytes are writable in this variant.
- R6: A 4-byte write with the address in 0x10–0x27 selects general window (addr−0x10)/4. If that window is implemented, the word is stored with its low log2(size) bits cleared and the window's type bits ORed in.
- R7: A 4-byte write with the address in 0x30–0x33 selects the ROM window. If that window is implemented, the word is stored with its low log2(size) bits cleared except bit 0, which keeps the written value.
- R8: A write to a window whose size is zero follows the byte-wise path of R4/R5.
- R9: Byte-wise writes clear the reserved bits of byte 0x05 (mask CMD_HI_RSVD), byte 0x06 (STS_LO_RSVD) and byte 0x07 (STS_HI_RSVD).
- R10: A multi-byte write drops the bytes beyond offset 0xFF, and offset 0x00 is not touched.
- R11: remap_pulse is high with ack for a write taken by the window path of R6/R7, and for a byte-wise write whose range covers 0x04 or 0x05. It stays low otherwise.
- R12: In the bridge variant, a write at 0x19 loads sec_bus from write byte 0, and a 2- or 4-byte write at 0x18 loads it from write byte 1. sec_bus changes only in this case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in the header |
| req_len | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Write data, little-endian |
| ack | output | 1 | Access acknowledged (one cycle after the request) |
| rdata | output | 32 | Read data, valid with ack on reads |
| remap_pulse | output | 1 | Decode-window remap strobe |
| sec_bus | output | 8 | Secondary bus number (bridge variant) |

## Verification
Two things can happen on the same edge. A single write can both store header bytes and trigger a side effect: the remap strobe on a window or command write, or a secondary bus number capture on a bridge write at 0x18/0x19. The bench provokes both cases with writes that hit such offsets. It judges the strobe and sec_bus in the acknowledge cycle, then reads the stored bytes back to confirm that the store used the masked value, or stored the plain value for the bus number. Writes that must not strobe are placed right next to ones that must (status-only, zero-size window), so any extra or missing pulse shows up at once.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int CFG_BYTES = 256;
  localparam int NUM_BAR   = 6;
  localparam int NUM_WIN   = NUM_BAR + 1;
  localparam int ROM_IDX   = NUM_BAR;
  localparam int WLOG_W    = 5;
  localparam int WTYPE_W   = 4;
  localparam int LANES     = 4;

  typedef logic [7:0] cfg_byte_t;

  typedef struct packed {
    logic      en;
    logic [7:0] idx;
    cfg_byte_t val;
  } lane_t;

  function automatic logic [2:0] len_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] rd_bytes(input logic [7:0] addr, input logic [1:0] code);
    logic [2:0] n;
    n = len_bytes(code);
    if (n == 3'd4 && addr <= 8'hFC) return 3'd4;
    if (n >= 3'd2 && addr <= 8'hFE) return 3'd2;
    return 3'd1;
  endfunction

  function automatic logic byte_locked(input logic [7:0] a, input logic plain_hdr);
    logic common;
    common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E) ||
             (a >= 8'h2C && a <= 8'h2F) || (a == 8'h3D);
    if (plain_hdr)
      return common || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    return common || (a >= 8'h38 && a <= 8'h3B);
  endfunction
endpackage

// File: rtl/cfg_write_decode.sv
module cfg_write_decode
  import cfg_hdr_pkg::*;
#(
  parameter logic                         PLAIN_HDR   = 1'b1,
  parameter logic [NUM_WIN*WLOG_W-1:0]    WIN_LOG2    = '0,
  parameter logic [NUM_BAR*WTYPE_W-1:0]   WIN_TYPE    = '0,
  parameter cfg_byte_t                    CMD_HI_RSVD = 8'hF8,
  parameter cfg_byte_t                    STS_LO_RSVD = 8'h47,
  parameter cfg_byte_t                    STS_HI_RSVD = 8'h01
) (
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [1:0]        len_code,
  input  logic [31:0]       wdata,
  output lane_t [LANES-1:0] lanes,
  output logic              win_hit,
  output logic              cmd_touch
);
  logic [2:0]        nb;
  logic              in_bar, in_rom;
  logic [2:0]        win;
  logic [WLOG_W-1:0] wlog;
  logic [WTYPE_W-1:0] wtype;
  logic [31:0]       keep_mask, word;

  always_comb begin
    nb     = len_bytes(len_code);
    in_bar = (addr >= 8'h10) && (addr <= 8'h27);
    in_rom = (addr >= 8'h30) && (addr <= 8'h33);
    win    = in_rom ? 3'(ROM_IDX) : 3'((addr - 8'h10) >> 2);
    wlog   = (in_bar || in_rom) ? WIN_LOG2[win*WLOG_W +: WLOG_W] : '0;
    wtype  = in_bar ? WIN_TYPE[win*WTYPE_W +: WTYPE_W] : '0;
    keep_mask = ~((32'd1 << wlog) - 32'd1);
    win_hit   = wr_en && (nb == 3'd4) && (in_bar || in_rom) && (wlog != '0);
    if (in_rom) word = wdata & (keep_mask | 32'd1);
    else        word = (wdata & keep_mask) | {28'd0, wtype};
    cmd_touch = wr_en && !win_hit && (addr < 8'h06) && (({1'b0, addr} + 9'(nb)) > 9'h004);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [8:0] tgt;
    cfg_byte_t  raw;
    always_comb begin
      tgt = {1'b0, addr} + 9'(k);
      raw = wdata[8*k +: 8];
      lanes[k].idx = tgt[7:0];
      lanes[k].en  = wr_en && (3'(k) < nb) && !tgt[8] &&
                     (win_hit || !byte_locked(tgt[7:0], PLAIN_HDR));
      if (win_hit) lanes[k].val = word[8*k +: 8];
      else begin
        case (tgt[7:0])
          8'h05:   lanes[k].val = raw & ~CMD_HI_RSVD;
          8'h06:   lanes[k].val = raw & ~STS_LO_RSVD;
          8'h07:   lanes[k].val = raw & ~STS_HI_RSVD;
          default: lanes[k].val = raw;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_hdr_pkg::*;
(
  input  cfg_byte_t   mem [CFG_BYTES],
  input  logic [7:0]  addr,
  input  logic [1:0]  len_code,
  output logic [31:0] data
);
  logic [2:0] n;
  always_comb begin
    n    = rd_bytes(addr, len_code);
    data = '0;
    for (int k = 0; k < LANES; k++) begin
      logic [7:0] idx;
      idx = addr + 8'(k);
      if (3'(k) < n) data[8*k +: 8] = mem[idx];
    end
  end
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]                VENDOR_ID   = 16'hABCD,
  parameter logic [15:0]                DEVICE_ID   = 16'h1234,
  parameter logic [15:0]                CLASS_CODE  = 16'h0200,
  parameter logic [7:0]                 HDR_TYPE    = 8'h00,
  parameter logic [15:0]                SUB_VENDOR  = 16'h5A5A,
  parameter logic [15:0]                SUB_DEVICE  = 16'hC3C3,
  parameter logic [NUM_WIN*WLOG_W-1:0]  WIN_LOG2    = {5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 5'd12, 5'd4},
  parameter logic [NUM_BAR*WTYPE_W-1:0] WIN_TYPE    = {4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 4'h1},
  parameter logic [7:0]                 CMD_HI_RSVD = 8'hF8,
  parameter logic [7:0]                 STS_LO_RSVD = 8'h47,
  parameter logic [7:0]                 STS_HI_RSVD = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        ack,
  output logic [31:0] rdata,
  output logic        remap_pulse,
  output logic [7:0]  sec_bus
);
  localparam logic PLAIN_HDR = (HDR_TYPE == 8'h00) || (HDR_TYPE == 8'h80);
  localparam logic IS_BRIDGE = !PLAIN_HDR;

  function automatic cfg_byte_t init_byte(input int i);
    case (i)
      8'h00: return VENDOR_ID[7:0];
      8'h01: return VENDOR_ID[15:8];
      8'h02: return DEVICE_ID[7:0];
      8'h03: return DEVICE_ID[15:8];
      8'h0A: return CLASS_CODE[7:0];
      8'h0B: return CLASS_CODE[15:8];
      8'h0E: return HDR_TYPE;
      8'h2C: return SUB_VENDOR[7:0];
      8'h2D: return SUB_VENDOR[15:8];
      8'h2E: return SUB_DEVICE[7:0];
      8'h2F: return SUB_DEVICE[15:8];
      default: begin
        if (i >= 16 && i < 16 + 4*NUM_BAR && (i % 4) == 0 &&
            WIN_LOG2[((i-16)/4)*WLOG_W +: WLOG_W] != '0)
          return {4'd0, WIN_TYPE[((i-16)/4)*WTYPE_W +: WTYPE_W]};
        return 8'h00;
      end
    endcase
  endfunction

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  cfg_byte_t         mem_q [CFG_BYTES];
  cfg_byte_t         mem_d [CFG_BYTES];
  lane_t [LANES-1:0] lanes;
  logic              win_hit, cmd_touch;
  logic [31:0]       rd_word;
  logic              rd_go, wr_go, sec_hit;
  cfg_byte_t         sec_d;
  logic              ack_q, remap_q;
  logic [31:0]       rdata_q;
  cfg_byte_t         sec_q;

  cfg_write_decode #(
    .PLAIN_HDR(PLAIN_HDR), .WIN_LOG2(WIN_LOG2), .WIN_TYPE(WIN_TYPE),
    .CMD_HI_RSVD(CMD_HI_RSVD), .STS_LO_RSVD(STS_LO_RSVD), .STS_HI_RSVD(STS_HI_RSVD)
  ) u_wdec (
    .wr_en(wr_go), .addr(req_addr), .len_code(req_len), .wdata(req_wdata),
    .lanes(lanes), .win_hit(win_hit), .cmd_touch(cmd_touch)
  );

  cfg_read_mux u_rmux (
    .mem(mem_q), .addr(req_addr), .len_code(req_len), .data(rd_word)
  );

  // next state
  always_comb begin
    rd_go   = req_valid && !req_write;
    wr_go   = req_valid && req_write;
    sec_hit = IS_BRIDGE && wr_go &&
              ((req_addr == 8'h19) || (req_addr == 8'h18 && req_len != 2'd0));
    sec_d   = (req_addr == 8'h19) ? req_wdata[7:0] : req_wdata[15:8];
    mem_d   = mem_q;
    for (int k = 0; k < LANES; k++)
      if (lanes[k].en) mem_d[lanes[k].idx] = lanes[k].val;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CFG_BYTES; i++) mem_q[i] <= init_byte(i);
    end else if (wr_go) begin
      mem_q <= mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      remap_q <= 1'b0;
      rdata_q <= '0;
      sec_q   <= '0;
    end else begin
      ack_q   <= req_valid;
      remap_q <= win_hit || cmd_touch;
      if (rd_go)   rdata_q <= rd_word;
      if (sec_hit) sec_q   <= sec_d;
    end
  end

  assign ack         = ack_q;
  assign rdata       = rdata_q;
  assign remap_pulse = remap_q;
  assign sec_bus     = sec_q;

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> ack); // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> !ack); // R2
  AST_REMAP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    remap_pulse |-> (ack && $past(req_write))); // R11
  AST_CMD_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_q[5] & CMD_HI_RSVD) == 8'h00); // R9
  AST_VENDOR_LOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
    $stable(mem_q[0])); // R4
  AST_SEC_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_addr != 8'h18 && req_addr != 8'h19) |=> $stable(sec_bus)); // R12
  AST_NARROW_READ_TOP: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_go && req_addr == 8'hFF) |=> (rdata[31:8] == 24'h0)); // R3
endmodule

// File: tb/tb_cfg_header_regs.sv
`timescale 1ns/1ps
module tb_cfg_header_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        v_n, v_b;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [1:0]  req_len;
  logic [31:0] req_wdata;
  logic        ack_n, ack_b, rm_n, rm_b;
  logic [31:0] rd_n, rd_b;
  logic [7:0]  sb_n, sb_b;
  int checks = 0;
  int fails  = 0;
  logic        g_ack, g_rm;
  logic [31:0] g_rd;
  logic [7:0]  g_sb;

  always #2 clk = ~clk;

  cfg_header_regs dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v_n), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .ack(ack_n), .rdata(rd_n), .remap_pulse(rm_n), .sec_bus(sb_n));

  cfg_header_regs #(.HDR_TYPE(8'h01), .CLASS_CODE(16'h0604),
                    .WIN_LOG2('0), .WIN_TYPE('0)) dut_br (
    .clk(clk), .rst_n(rst_n), .req_valid(v_b), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .ack(ack_b), .rdata(rd_b), .remap_pulse(rm_b), .sec_bus(sb_b));

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [1:0]  len;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 2'd2, 32'h0,        32'h1234ABCD, 8'd1},  // R1 ids
    '{1'b0, 8'h08, 2'd2, 32'h0,        32'h02000000, 8'd1},  // R1 class
    '{1'b0, 8'h2C, 2'd2, 32'h0,        32'hC3C35A5A, 8'd1},  // R1 subsystem
    '{1'b0, 8'h10, 2'd2, 32'h0,        32'h00000001, 8'd1},  // R1 type preload
    '{1'b0, 8'h14, 2'd2, 32'h0,        32'h00000008, 8'd1},  // R1
    '{1'b1, 8'h10, 2'd2, 32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b0, 8'h10, 2'd2, 32'h0,        32'hFFFFFFF1, 8'd6},  // R6
    '{1'b1, 8'h14, 2'd2, 32'h12345678, 32'h0,        8'd6},
    '{1'b0, 8'h14, 2'd2, 32'h0,        32'h12345008, 8'd6},  // R6
    '{1'b1, 8'h30, 2'd2, 32'hABCDE7FF, 32'h0,        8'd7},
    '{1'b0, 8'h30, 2'd2, 32'h0,        32'hABCDE001, 8'd7},  // R7
    '{1'b1, 8'h30, 2'd2, 32'h00001802, 32'h0,        8'd7},
    '{1'b0, 8'h30, 2'd2, 32'h0,        32'h00001800, 8'd7},  // R7
    '{1'b1, 8'h18, 2'd2, 32'h11223344, 32'h0,        8'd8},
    '{1'b0, 8'h18, 2'd2, 32'h0,        32'h00000000, 8'd8},  // R8
    '{1'b1, 8'h3C, 2'd2, 32'hAAAAAAAA, 32'h0,        8'd4},
    '{1'b0, 8'h3C, 2'd2, 32'h0,        32'hAAAA00AA, 8'd4},  // R4
    '{1'b1, 8'h00, 2'd1, 32'h0000FFFF, 32'h0,        8'd4},
    '{1'b0, 8'h00, 2'd2, 32'h0,        32'h1234ABCD, 8'd4},  // R4
    '{1'b1, 8'h04, 2'd2, 32'hFFFFFFFF, 32'h0,        8'd9},
    '{1'b0, 8'h04, 2'd2, 32'h0,        32'hFEB807FF, 8'd9},  // R9
    '{1'b1, 8'h40, 2'd2, 32'h87654321, 32'h0,        8'd3},
    '{1'b0, 8'h40, 2'd0, 32'h0,        32'h00000021, 8'd3},  // R3
    '{1'b0, 8'h41, 2'd1, 32'h0,        32'h00006543, 8'd3},  // R3
    '{1'b0, 8'h40, 2'd3, 32'h0,        32'h87654321, 8'd3},  // R3
    '{1'b1, 8'hFC, 2'd2, 32'hDEADBEEF, 32'h0,        8'd3},
    '{1'b0, 8'hFD, 2'd2, 32'h0,        32'h0000ADBE, 8'd3},  // R3 fallback
    '{1'b0, 8'hFF, 2'd2, 32'h0,        32'h000000DE, 8'd3},  // R3
    '{1'b1, 8'hFE, 2'd2, 32'h11223344, 32'h0,        8'd10},
    '{1'b0, 8'hFE, 2'd1, 32'h0,        32'h00003344, 8'd10}, // R10
    '{1'b0, 8'h00, 2'd1, 32'h0,        32'h0000ABCD, 8'd10}, // R10
    '{1'b0, 8'h0E, 2'd0, 32'h0,        32'h00000000, 8'd1},  // R1
    '{1'b1, 8'h08, 2'd0, 32'h000000FF, 32'h0,        8'd4},
    '{1'b0, 8'h08, 2'd2, 32'h0,        32'h02000000, 8'd4}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit br, input bit we, input logic [7:0] a,
                        input logic [1:0] l, input logic [31:0] d);
    @(negedge clk);
    req_write = we; req_addr = a; req_len = l; req_wdata = d;
    if (br) v_b = 1'b1; else v_n = 1'b1;
    @(negedge clk);
    v_n = 1'b0; v_b = 1'b0;
    g_ack = br ? ack_b : ack_n;
    g_rd  = br ? rd_b  : rd_n;
    g_rm  = br ? rm_b  : rm_n;
    g_sb  = br ? sb_b  : sb_n;
  endtask

  initial begin
    v_n = 1'b0; v_b = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", {31'd0, ack_n}, 32'd0);
    chk("R1 rdata in reset", rd_n, 32'd0);
    chk("R1 remap in reset", {31'd0, rm_n}, 32'd0);
    chk("R1 sec_bus in reset", {24'd0, sb_b}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(1'b0, VECS[i].we, VECS[i].addr, VECS[i].len, VECS[i].wd);
      if (!VECS[i].we) chk($sformatf("R%0d vec %0d", VECS[i].req, i), g_rd, VECS[i].exp);
    end

    // R2: ack only in the cycle after the request
    access(1'b0, 1'b0, 8'h00, 2'd0, 32'h0);
    chk("R2 ack after request", {31'd0, g_ack}, 32'd1);
    @(negedge clk);
    chk("R2 ack drops", {31'd0, ack_n}, 32'd0);

    // R11: remap strobe
    access(1'b0, 1'b1, 8'h04, 2'd0, 32'h3);
    chk("R11 cmd byte write", {31'd0, g_rm}, 32'd1);
    access(1'b0, 1'b1, 8'h06, 2'd1, 32'h0);
    chk("R11 status only", {31'd0, g_rm}, 32'd0);
    access(1'b0, 1'b1, 8'h03, 2'd1, 32'h0);
    chk("R11 span into cmd", {31'd0, g_rm}, 32'd1);
    access(1'b0, 1'b1, 8'h10, 2'd2, 32'h00000100);
    chk("R11 window write", {31'd0, g_rm}, 32'd1);
    access(1'b0, 1'b1, 8'h18, 2'd2, 32'h00000100);
    chk("R11 empty window", {31'd0, g_rm}, 32'd0);
    access(1'b0, 1'b0, 8'h04, 2'd2, 32'h0);
    chk("R11 read no strobe", {31'd0, g_rm}, 32'd0);

    // R5 / R8: bridge variant
    access(1'b1, 1'b1, 8'h10, 2'd2, 32'h55667788);
    access(1'b1, 1'b0, 8'h10, 2'd2, 32'h0);
    chk("R8 bridge empty window bytewise", g_rd, 32'h55667788);
    access(1'b1, 1'b1, 8'h38, 2'd2, 32'hFFFFFFFF);
    access(1'b1, 1'b0, 8'h38, 2'd2, 32'h0);
    chk("R5 bridge rom locked", g_rd, 32'h0);
    access(1'b1, 1'b1, 8'h30, 2'd2, 32'h12345678);
    access(1'b1, 1'b0, 8'h30, 2'd2, 32'h0);
    chk("R5 bridge 0x30 writable", g_rd, 32'h12345678);
    access(1'b1, 1'b1, 8'h0C, 2'd2, 32'hFFFFFFFF);
    access(1'b1, 1'b0, 8'h0C, 2'd2, 32'h0);
    chk("R5 bridge header type locked", g_rd, 32'hFF01FFFF);

    // R12: secondary bus number
    access(1'b1, 1'b1, 8'h19, 2'd0, 32'h07);
    chk("R12 byte at 0x19", {24'd0, g_sb}, 32'h07);
    access(1'b1, 1'b1, 8'h18, 2'd1, 32'h0900);
    chk("R12 word at 0x18", {24'd0, g_sb}, 32'h09);
    access(1'b1, 1'b0, 8'h18, 2'd1, 32'h0);
    chk("R12 bytes stored too", g_rd, 32'h00000900);
    access(1'b1, 1'b1, 8'h18, 2'd0, 32'h33);
    chk("R12 byte at 0x18 ignored", {24'd0, g_sb}, 32'h09);
    access(1'b0, 1'b1, 8'h19, 2'd0, 32'h44);
    chk("R12 plain header no capture", {24'd0, sb_n}, 32'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule